// File: doc/BRIEF.md
# Parallel I/Q Output Port with Request/Acknowledge Handshake

This block sends complex baseband samples from a set of gain-control channels to an external processor over one parallel bus. Each channel delivers a sample with a one-cycle valid strobe carrying an I byte, a Q byte and a gain value. The port stores the sample in a one-deep holding slot for that channel and raises a request. When the receiver holds acknowledge high, the port puts one packed I/Q word on the bus in each cycle. Each word carries a channel tag and an I/Q indicator.

When the gain-word option is on, each I/Q word is followed in the next accepted cycle by a gain word. A gain indicator of its own marks that word. Pending channels are served lowest index first. A sample that arrives while its channel still holds an unsent sample replaces the old one and sets a sticky overflow flag.

Top module: `iq_out_port`

## Requirements
- R1: In a cycle with iq_flag high, bus[15:8] carries the I byte and bus[7:0] the Q byte of the sample being sent.
- R2: In every cycle with iq_flag or gain_flag high, ch equals the binary index of the channel whose data is on the bus.
- R3: req is high in every cycle in which any channel holds an unsent sample or a gain word is still owed, and low otherwise.
- R4: When several channels are pending, their samples are sent in ascending channel-index order.
- R5: With acknowledge held high and gain words off, pending samples go out in consecutive cycles and iq_flag stays high without a gap until the last one has been sent.
- R6: With gain_en high, the next acknowledged cycle after each I/Q word carries {4'b0000, gain[11:0]} of the same sample, with gain_flag high, iq_flag low and the same ch.
- R7: With gain_en low, gain_flag is never high and no gain word is sent.
- R8: In a cycle with ack low, bus and ch are zero and both indicators are low. No pending data is lost and the transfer resumes where it stopped once ack returns high.
- R9: A sample whose valid strobe arrives while the same channel still holds an unsent sample overwrites it, so only the newer sample is sent. The arrival also sets ovf, which stays high until reset.
- R10: Synchronous active-high reset clears all pending samples, any owed gain word, ovf and req.
- R11: A sample strobed in cycle n can first appear on the bus in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| gain_en | input | 1 | Enables the trailing gain word |
| ack | input | 1 | Receiver ready; a word is transferred in each cycle it is high |
| smp_valid | input | NCH | Per-channel sample strobe |
| smp_i | input | NCH*8 | Per-channel I byte, channel c at [c*8 +: 8] |
| smp_q | input | NCH*8 | Per-channel Q byte, channel c at [c*8 +: 8] |
| smp_gain | input | NCH*12 | Per-channel gain, channel c at [c*12 +: 12] |
| req | output | 1 | Data waiting to be sent |
| bus | output | 16 | Packed I/Q word or zero-padded gain word |
| ch | output | 3 | Source channel of the current word |
| iq_flag | output | 1 | Bus carries an I/Q word |
| gain_flag | output | 1 | Bus carries a gain word |
| ovf | output | 1 | Sticky sample-overwrite flag |

## Verification
The assertions assume that gain_en changes only while req is low. If gain_en drops while a gain word is owed, that word is dropped, and the handshake checks would see a request vanish without a transfer. The stimulus changes gain_en only after it has drained the port with acknowledge held high. Elsewhere, valid strobes and acknowledge are driven freely, including random patterns that force overwrites and long stalls.

// File: rtl/iq_out_port.sv
module iq_out_port #(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int GW  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     gain_en,
  input  logic                     ack,
  input  logic [NCH-1:0]           smp_valid,
  input  logic [NCH*DW-1:0]        smp_i,
  input  logic [NCH*DW-1:0]        smp_q,
  input  logic [NCH*GW-1:0]        smp_gain,
  output logic                     req,
  output logic [2*DW-1:0]          bus,
  output logic [$clog2(NCH)-1:0]   ch,
  output logic                     iq_flag,
  output logic                     gain_flag,
  output logic                     ovf
);
  localparam int CHW = $clog2(NCH);
  localparam int BW  = 2 * DW;

  logic [NCH-1:0] pend;
  logic [DW-1:0]  hold_i [NCH];
  logic [DW-1:0]  hold_q [NCH];
  logic [GW-1:0]  hold_g [NCH];
  logic           owe_g;
  logic [CHW-1:0] g_ch;
  logic [GW-1:0]  g_val;
  logic [CHW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (pend[c]) sel = CHW'(c);
  end

  wire send_iq = ack && !owe_g && (|pend);
  wire send_g  = ack && owe_g && gain_en;

  assign req       = (|pend) || owe_g;
  assign iq_flag   = send_iq;
  assign gain_flag = send_g;
  assign bus = send_g  ? {{(BW-GW){1'b0}}, g_val} :
               send_iq ? {hold_i[sel], hold_q[sel]} : '0;
  assign ch  = send_g ? g_ch : (send_iq ? sel : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      owe_g <= 1'b0;
      ovf   <= 1'b0;
      g_ch  <= '0;
      g_val <= '0;
    end else begin
      if (send_iq && gain_en) begin
        owe_g <= 1'b1;
        g_ch  <= sel;
        g_val <= hold_g[sel];
      end else if (send_g || !gain_en) begin
        owe_g <= 1'b0;
      end
      for (int c = 0; c < NCH; c++) begin
        if (smp_valid[c]) begin
          pend[c] <= 1'b1;
          if (pend[c] && !(send_iq && sel == CHW'(c))) ovf <= 1'b1;
        end else if (send_iq && sel == CHW'(c)) begin
          pend[c] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (smp_valid[c]) begin
        hold_i[c] <= smp_i[c*DW +: DW];
        hold_q[c] <= smp_q[c*DW +: DW];
        hold_g[c] <= smp_gain[c*GW +: GW];
      end
    end
  end
endmodule

// File: rtl/iq_out_port_chk.sv
module iq_out_port_chk #(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   gain_en,
  input logic                   ack,
  input logic                   req,
  input logic [2*DW-1:0]        bus,
  input logic [$clog2(NCH)-1:0] ch,
  input logic                   iq_flag,
  input logic                   gain_flag,
  input logic                   ovf
);
  a_r3_flag_needs_req: assert property (@(posedge clk) disable iff (rst)
    (iq_flag || gain_flag) |-> req);
  a_r8_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
    !ack |-> (bus == '0 && ch == '0 && !iq_flag && !gain_flag));
  a_r8_stall_keeps_req: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(iq_flag && gain_flag));
  a_r6_gain_pad_zero: assert property (@(posedge clk) disable iff (rst)
    gain_flag |-> bus[2*DW-1:12] == '0);
  a_r6_gain_owed: assert property (@(posedge clk) disable iff (rst)
    (iq_flag && gain_en) |=> (req && !iq_flag));
  a_r7_no_gain_when_off: assert property (@(posedge clk) disable iff (rst)
    !gain_en |-> !gain_flag);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

bind iq_out_port iq_out_port_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .gain_en(gain_en), .ack(ack), .req(req), .bus(bus),
  .ch(ch), .iq_flag(iq_flag), .gain_flag(gain_flag), .ovf(ovf));

// File: tb/iq_out_port_tb_top.sv
module iq_out_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 8;
  localparam int GW  = 12;

  logic clk = 1'b0;
  logic rst, gain_en, ack;
  logic [NCH-1:0]    smp_valid;
  logic [NCH*DW-1:0] smp_i, smp_q;
  logic [NCH*GW-1:0] smp_gain;
  logic req, iq_flag, gain_flag, ovf;
  logic [15:0] bus;
  logic [2:0]  ch;

  iq_out_port #(.NCH(NCH), .DW(DW), .GW(GW)) dut_i (
    .clk(clk), .rst(rst), .gain_en(gain_en), .ack(ack), .smp_valid(smp_valid),
    .smp_i(smp_i), .smp_q(smp_q), .smp_gain(smp_gain), .req(req), .bus(bus),
    .ch(ch), .iq_flag(iq_flag), .gain_flag(gain_flag), .ovf(ovf));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  bit m_pend [NCH];
  int m_i [NCH], m_q [NCH], m_g [NCH];
  bit m_owe, m_ovf;
  int m_gch, m_gval;
  int sent_log [$];

  int n_chk = 0, n_fail = 0;
  string tag = "R10";

  task automatic chk(string r, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s/%s %s actual=%0h expected=%0h at %0t", tag, r, what, got, exp, $time);
    end
  endtask

  function automatic int lowest();
    for (int c = 0; c < NCH; c++) if (m_pend[c]) return c;
    return -1;
  endfunction

  function automatic bit any_pend();
    return lowest() >= 0;
  endfunction

  task automatic tick();
    int lo, e_bus, e_ch;
    bit e_iq, e_g;
    #(CLK_PERIOD/4);
    lo = lowest();
    e_bus = 0; e_ch = 0; e_iq = 0; e_g = 0;
    if (ack && m_owe && gain_en) begin
      e_g = 1; e_bus = m_gval; e_ch = m_gch;
    end else if (ack && !m_owe && lo >= 0) begin
      e_iq = 1; e_bus = m_i[lo] * 256 + m_q[lo]; e_ch = lo;
    end
    if (!rst) begin
      chk("R3", "req", int'(req), int'(any_pend() || m_owe));
      chk("R1", "bus", int'(bus), e_bus);
      chk("R2", "ch", int'(ch), e_ch);
      chk("R5", "iq_flag", int'(iq_flag), int'(e_iq));
      chk("R6", "gain_flag", int'(gain_flag), int'(e_g));
      chk("R9", "ovf", int'(ovf), int'(m_ovf));
    end
    if (rst) begin
      for (int c = 0; c < NCH; c++) m_pend[c] = 0;
      m_owe = 0; m_ovf = 0; m_gch = 0; m_gval = 0;
    end else begin
      if (e_iq) begin
        sent_log.push_back(lo);
        m_pend[lo] = 0;
        if (gain_en) begin m_owe = 1; m_gch = lo; m_gval = m_g[lo]; end
      end else if (e_g || !gain_en) begin
        m_owe = 0;
      end
      for (int c = 0; c < NCH; c++) begin
        if (smp_valid[c]) begin
          if (m_pend[c]) m_ovf = 1;
          m_pend[c] = 1;
          m_i[c] = int'(smp_i[c*DW +: DW]);
          m_q[c] = int'(smp_q[c*DW +: DW]);
          m_g[c] = int'(smp_gain[c*GW +: GW]);
        end
      end
    end
    @(negedge clk);
    smp_valid = '0;
  endtask

  task automatic load(int c, int i, int q, int g);
    smp_valid[c] = 1'b1;
    smp_i[c*DW +: DW] = DW'(i);
    smp_q[c*DW +: DW] = DW'(q);
    smp_gain[c*GW +: GW] = GW'(g);
  endtask

  task automatic drain();
    ack = 1'b1;
    for (int k = 0; k < 40; k++) tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; gain_en = 1'b0; ack = 1'b0;
    smp_valid = '0; smp_i = '0; smp_q = '0; smp_gain = '0;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R10: reset state
    tag = "R10";
    tick(); tick();

    // R11: single sample, visible the cycle after its strobe
    tag = "R11";
    ack = 1'b1;
    load(3, 8'hA5, 8'h3C, 12'h123);
    tick();
    chk("R11", "req after strobe", int'(req), 1);
    chk("R11", "iq_flag after strobe", int'(iq_flag), 1);
    tick(); tick();

    // R4 / R5: several channels, ascending order, back to back
    tag = "R4";
    sent_log.delete();
    ack = 1'b0;
    load(5, 8'h55, 8'h05, 1); load(1, 8'h11, 8'h01, 2); load(6, 8'h66, 8'h06, 3);
    tick();
    ack = 1'b1;
    tick(); tick(); tick(); tick();
    chk("R4", "order count", sent_log.size(), 3);
    if (sent_log.size() == 3) begin
      chk("R4", "first", sent_log[0], 1);
      chk("R4", "second", sent_log[1], 5);
      chk("R4", "third", sent_log[2], 6);
    end

    // R8: stall with ack low, then resume
    tag = "R8";
    ack = 1'b0;
    load(2, 8'h22, 8'h02, 5); load(4, 8'h44, 8'h04, 6);
    for (int k = 0; k < 5; k++) tick();
    chk("R8", "req held in stall", int'(req), 1);
    ack = 1'b1; tick();
    ack = 1'b0; tick(); tick();
    ack = 1'b1; tick(); tick();

    // R6: gain words after each I/Q word, with stalls in between
    tag = "R6";
    gain_en = 1'b1;
    load(0, 8'h01, 8'h02, 12'hABC); load(7, 8'hF0, 8'h0F, 12'hFFF);
    tick();
    for (int k = 0; k < 8; k++) begin ack = k[0] | k[2]; tick(); end
    drain();

    // R9: overwrite before send
    tag = "R9";
    ack = 1'b0;
    load(3, 8'h01, 8'h01, 1); tick();
    load(3, 8'h99, 8'h77, 9); tick();
    chk("R9", "ovf set", int'(ovf), 1);
    drain();
    gain_en = 1'b0;
    tick();

    // R7: gain disabled, random traffic
    tag = "R7";
    for (int k = 0; k < 300; k++) begin
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 9) == 0) load(c, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 4095));
      ack = ($urandom_range(0, 9) < 7);
      tick();
    end
    drain();
    gain_en = 1'b1;
    tag = "R6";
    for (int k = 0; k < 300; k++) begin
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 11) == 0) load(c, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 4095));
      ack = ($urandom_range(0, 9) < 8);
      tick();
    end

    // R10: reset with pending work
    tag = "R10";
    ack = 1'b0;
    load(1, 1, 1, 1); load(6, 2, 2, 2); tick();
    rst = 1'b1; tick();
    rst = 1'b0; ack = 1'b1; tick();
    chk("R10", "req after reset", int'(req), 0);
    chk("R10", "ovf after reset", int'(ovf), 0);
    tick();

    summary();
    $finish;
  end
endmodule